// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit sits between instruction decode and the execute stage. It accepts one request at a time. A request carries a decoded addressing-mode code, a field from the instruction (an address, displacement or literal), a register selector and the program counter value. The program counter value already points past the current instruction. The unit forms the effective address from that request and then issues the memory reads the mode calls for, which may be none, one, or two dependent reads. It returns the effective address, the final operand and the number of reads it made.

The unit reads the general register file through one combinational read port, addressed by the request's selector. The index register and the stack pointer come in as plain inputs. Post-increment and pre-decrement modes write the adjusted register back through a single write port, in the same cycle the request is accepted.

Memory is a single-port synchronous read port. Read data is valid in the cycle after the read strobe. Requests use a valid/ready handshake. `req_ready` is high only while the unit is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Results also use valid/ready. `res_valid` stays high and every result field stays frozen until the consumer raises `res_ready`. Only after that does the unit return to idle and accept a new request.

Top module: `opf_unit`

## Requirements
- R1: Mode code 0 (literal) returns the field as both operand and effective address and makes no memory read.
- R2: Mode code 1 (register value) returns the selected register's contents as the operand and the selector number as the effective address, with no memory read.
- R3: Mode code 2 (absolute) uses the field as the effective address and makes one read there; that read's data is the operand.
- R4: Mode code 3 (pointer) reads memory at the field first, takes the returned word as the effective address, then reads there for the operand, making exactly two reads in that order.
- R5: Mode codes 4 (register pointer, EA = register), 5 (indexed, EA = field + index register) and 6 (based, EA = register + field) each make one read at the effective address; all sums wrap modulo 2^AW.
- R6: Mode code 7 (relative) forms EA = program counter input + field, with the field read as a signed two's-complement displacement and the sum wrapping; one read.
- R7: Mode code 8 (stack top) uses the stack pointer input as the effective address and makes one read.
- R8: Mode code 9 (post-increment) reads at the selected register's old value and writes back old + STEP; mode code 10 (pre-decrement) reads at old - STEP and writes back old - STEP. No other mode writes a register.
- R9: `res_nreads` equals the number of read strobes issued for that request (0, 1 or 2).
- R10: `res_valid` rises 1 + 2·N clock edges after the accepting edge, where N is the read count: each read takes one issue cycle and one capture cycle.
- R11: While `res_valid` is high and `res_ready` is low, all result outputs hold and `req_ready` stays low.
- R12: Mode codes 11 to 15 are handled as mode 0.
- R13: After reset `req_ready` is high and `res_valid` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_mode | input | 4 | Addressing-mode code |
| req_field | input | AW | Literal, address or displacement |
| req_sel | input | RSW | General register selector |
| req_pc | input | AW | Program counter of the next instruction |
| ix_val | input | DW | Index register contents |
| sp_val | input | DW | Stack pointer contents |
| rf_sel | output | RSW | Register file read/write index |
| rf_rdata | input | DW | Register file read data (combinational) |
| rf_we | output | 1 | Register write-back strobe |
| rf_wdata | output | DW | Register write-back value |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Memory read data, one cycle after strobe |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_ea | output | AW | Effective address |
| res_data | output | DW | Final operand |
| res_nreads | output | 2 | Memory reads made for this request |

## Verification
Each addressing mode is applied with fields chosen so that a wrong formula gives a different answer. The indexed, based and relative modes get fields near the top of the address space, so a sum that fails to wrap or a displacement read as unsigned shows up in the effective address. Bench memory holds a scrambling function of the address, so the operand from a pointer, the pointer itself and an operand read from the wrong address all differ. The read-strobe count and the edge count to `res_valid` separate the 0-, 1- and 2-read paths. Auto-modify modes are followed by a register-value fetch of the same register to show the write-back, a stalled consumer tests the result hold, and unused mode codes are compared with literal mode.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [3:0] {
    M_LIT     = 4'd0,
    M_REGV    = 4'd1,
    M_ABS     = 4'd2,
    M_PTR     = 4'd3,
    M_RPTR    = 4'd4,
    M_IDX     = 4'd5,
    M_BASED   = 4'd6,
    M_REL     = 4'd7,
    M_STK     = 4'd8,
    M_POSTINC = 4'd9,
    M_PREDEC  = 4'd10
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_CAPT  = 2'd2,
    S_DONE  = 2'd3
  } state_e;
endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int RSW  = 3,
  parameter int STEP = 1
) (
  input  logic [3:0]     mode,
  input  logic [AW-1:0]  field,
  input  logic [RSW-1:0] sel,
  input  logic [AW-1:0]  pc,
  input  logic [DW-1:0]  reg_val,
  input  logic [DW-1:0]  ix_val,
  input  logic [DW-1:0]  sp_val,
  output logic [AW-1:0]  ea,
  output logic [1:0]     nreads,
  output logic [DW-1:0]  early_data,
  output logic           wb_en,
  output logic [DW-1:0]  wb_val
);
  import opf_pkg::*;

  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  logic [AW-1:0] reg_a, ix_a, sp_a;
  assign reg_a = reg_val[AW-1:0];
  assign ix_a  = ix_val[AW-1:0];
  assign sp_a  = sp_val[AW-1:0];

  always_comb begin
    ea         = field;
    nreads     = 2'd0;
    early_data = DW'(field);
    wb_en      = 1'b0;
    wb_val     = reg_val;
    case (mode)
      M_REGV: begin
        ea         = AW'(sel);
        early_data = reg_val;
      end
      M_ABS:   nreads = 2'd1;
      M_PTR:   nreads = 2'd2;
      M_RPTR:  begin ea = reg_a;         nreads = 2'd1; end
      M_IDX:   begin ea = field + ix_a;  nreads = 2'd1; end
      M_BASED: begin ea = reg_a + field; nreads = 2'd1; end
      M_REL:   begin ea = pc + field;    nreads = 2'd1; end
      M_STK:   begin ea = sp_a;          nreads = 2'd1; end
      M_POSTINC: begin
        ea     = reg_a;
        nreads = 2'd1;
        wb_en  = 1'b1;
        wb_val = DW'(reg_a + STEP_A);
      end
      M_PREDEC: begin
        ea     = reg_a - STEP_A;
        nreads = 2'd1;
        wb_en  = 1'b1;
        wb_val = DW'(reg_a - STEP_A);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] ea_in,
  input  logic [1:0]    nreads_in,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_ea,
  output logic [DW-1:0] res_data,
  output logic [1:0]    res_nreads
);
  import opf_pkg::*;

  state_e        state;
  logic [AW-1:0] ea_q;
  logic [DW-1:0] data_q;
  logic [1:0]    left_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ea_q   <= '0;
      data_q <= '0;
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          ea_q   <= ea_in;
          data_q <= data_in;
          left_q <= nreads_in;
          cnt_q  <= '0;
          state  <= (nreads_in == 2'd0) ? S_DONE : S_ISSUE;
        end
        S_ISSUE: begin
          cnt_q  <= cnt_q + 2'd1;
          left_q <= left_q - 2'd1;
          state  <= S_CAPT;
        end
        S_CAPT: begin
          if (left_q != 2'd0) begin
            ea_q  <= mem_rdata[AW-1:0];
            state <= S_ISSUE;
          end else begin
            data_q <= mem_rdata;
            state  <= S_DONE;
          end
        end
        S_DONE: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign mem_re     = (state == S_ISSUE);
  assign mem_addr   = ea_q;
  assign res_valid  = (state == S_DONE);
  assign res_ea     = ea_q;
  assign res_data   = data_q;
  assign res_nreads = cnt_q;

  // R10: a read strobe is always followed by a capture cycle
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  // R11: result held under back-pressure
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_ea) &&
                                   $stable(res_data) && $stable(res_nreads)));

  // R9: never more than two reads reported
  assert_nreads_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_nreads <= 2'd2));

  // R13: no read strobe while idle
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_re && !res_valid));
endmodule

// File: rtl/opf_unit.sv
module opf_unit #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int STEP = 1,
  localparam int RSW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [3:0]     req_mode,
  input  logic [AW-1:0]  req_field,
  input  logic [RSW-1:0] req_sel,
  input  logic [AW-1:0]  req_pc,
  input  logic [DW-1:0]  ix_val,
  input  logic [DW-1:0]  sp_val,
  output logic [RSW-1:0] rf_sel,
  input  logic [DW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [DW-1:0]  rf_wdata,
  output logic           mem_re,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [AW-1:0]  res_ea,
  output logic [DW-1:0]  res_data,
  output logic [1:0]     res_nreads
);
  logic          busy, accept, wb_en;
  logic [AW-1:0] ea_c;
  logic [1:0]    nreads_c;
  logic [DW-1:0] early_c;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign rf_sel    = req_sel;
  assign rf_we     = accept && wb_en;

  opf_ea_calc #(.AW(AW), .DW(DW), .RSW(RSW), .STEP(STEP)) u_ea (
    .mode(req_mode), .field(req_field), .sel(req_sel), .pc(req_pc),
    .reg_val(rf_rdata), .ix_val(ix_val), .sp_val(sp_val),
    .ea(ea_c), .nreads(nreads_c), .early_data(early_c),
    .wb_en(wb_en), .wb_val(rf_wdata)
  );

  opf_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .ea_in(ea_c), .nreads_in(nreads_c), .data_in(early_c),
    .busy(busy), .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_ea(res_ea), .res_data(res_data), .res_nreads(res_nreads)
  );

  // R8: register write-back only on an accepted request
  assert_wb_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (req_valid && req_ready));

  // R11: no new request while a result is pending
  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R10: a read strobe only follows an accepted request, never in the accept cycle
  assert_no_early_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !mem_re);
endmodule

// File: tb/tb_opf_unit.sv
module tb_opf_unit;
  localparam int AW = 16, DW = 16, NREG = 8, RSW = 3;

  logic           clk = 0, rst_n = 0;
  logic           req_valid = 0, res_ready = 1;
  logic           req_ready, rf_we, mem_re, res_valid;
  logic [3:0]     req_mode = 0;
  logic [AW-1:0]  req_field = 0, req_pc = 16'h0102;
  logic [RSW-1:0] req_sel = 0, rf_sel;
  logic [DW-1:0]  ix_val = 16'h0064, sp_val = 16'hFF00;
  logic [DW-1:0]  rf_rdata, rf_wdata, mem_rdata = 0, res_data;
  logic [AW-1:0]  mem_addr, res_ea;
  logic [1:0]     res_nreads;
  logic [DW-1:0]  regs [NREG];

  int checks = 0, fails = 0, strobes = 0;
  logic [AW-1:0] first_addr;

  always #10 clk = ~clk;

  opf_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_field(req_field), .req_sel(req_sel), .req_pc(req_pc),
    .ix_val(ix_val), .sp_val(sp_val), .rf_sel(rf_sel), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_ready(res_ready),
    .res_ea(res_ea), .res_data(res_data), .res_nreads(res_nreads)
  );

  function automatic logic [15:0] memval(input logic [15:0] a);
    logic [15:0] m;
    m = a * 16'd40503;
    return m + 16'h1234;
  endfunction

  assign rf_rdata = regs[rf_sel];

  always @(posedge clk) begin
    if (rf_we) regs[rf_sel] <= rf_wdata;
    if (mem_re) begin
      mem_rdata <= memval(mem_addr);
      if (strobes == 0) first_addr <= mem_addr;
      strobes <= strobes + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected results from the requirements, using the bench register copy.
  task automatic model(input logic [3:0] m, input logic [15:0] f, input int s,
                       output logic [15:0] ea, output logic [15:0] d, output int n);
    logic [15:0] r;
    r = regs[s];
    n = 1;
    case (m)
      4'd1: begin ea = 16'(s); d = r; n = 0; end
      4'd2: ea = f;
      4'd3: begin ea = memval(f); n = 2; end
      4'd4: ea = r;
      4'd5: ea = f + ix_val;
      4'd6: ea = r + f;
      4'd7: ea = req_pc + f;
      4'd8: ea = sp_val;
      4'd9: ea = r;
      4'd10: ea = r - 16'd1;
      default: begin ea = f; d = f; n = 0; end
    endcase
    if (n != 0) d = memval(ea);
  endtask

  task automatic run(input string req, input logic [3:0] m, input logic [15:0] f,
                     input int s, input int exp_n, input int hold);
    logic [15:0] eea, ed;
    int en, lat, s0;
    logic [15:0] kea, kd;
    model(m, f, s, eea, ed, en);
    while (!req_ready) @(negedge clk);
    req_mode = m; req_field = f; req_sel = RSW'(s); req_valid = 1;
    s0 = strobes;
    strobes = 0;
    res_ready = (hold == 0);
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    req_valid = 0;
    while (!res_valid && lat < 20) begin @(negedge clk); lat++; end
    chk({req, " ea"}, 32'(res_ea), 32'(eea));
    chk({req, " data"}, 32'(res_data), 32'(ed));
    chk({req, " R9 nreads"}, 32'(res_nreads), 32'(exp_n));
    chk({req, " R9 strobes"}, 32'(strobes), 32'(exp_n));
    chk({req, " R10 latency"}, 32'(lat), 32'(1 + 2 * exp_n));
    if (m == 4'd3) chk({req, " R4 first read addr"}, 32'(first_addr), 32'(f));
    if (hold > 0) begin
      kea = res_ea; kd = res_data;
      for (int i = 0; i < hold; i++) @(negedge clk);
      chk("R11 valid held", 32'(res_valid), 32'd1);
      chk("R11 ea held", 32'(res_ea), 32'(kea));
      chk("R11 data held", 32'(res_data), 32'(kd));
      chk("R11 req_ready low", 32'(req_ready), 32'd0);
      res_ready = 1;
    end
    @(posedge clk);
    @(negedge clk);
    s0 = s0;
  endtask

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] field;
    logic [2:0]  sel;
    logic [1:0]  n;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  16'h00AB, 3'd0, 2'd0},   // R1
    '{4'd1,  16'h0000, 3'd3, 2'd0},   // R2
    '{4'd2,  16'h0200, 3'd0, 2'd1},   // R3
    '{4'd3,  16'h0200, 3'd0, 2'd2},   // R4
    '{4'd3,  16'hFFFF, 3'd0, 2'd2},   // R4 top of space
    '{4'd4,  16'h0000, 3'd1, 2'd1},   // R5 register pointer
    '{4'd5,  16'h0400, 3'd0, 2'd1},   // R5 indexed
    '{4'd5,  16'hFFC0, 3'd0, 2'd1},   // R5 indexed wrap
    '{4'd6,  16'h0010, 3'd5, 2'd1},   // R5 based
    '{4'd6,  16'hF000, 3'd7, 2'd1},   // R5 based wrap
    '{4'd7,  16'h0050, 3'd0, 2'd1},   // R6 forward
    '{4'd7,  16'hFFF0, 3'd0, 2'd1},   // R6 backward
    '{4'd8,  16'h1234, 3'd0, 2'd1},   // R7
    '{4'd13, 16'h0777, 3'd2, 2'd0}    // R12
  };

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) regs[i] = 16'h1000 + 16'(i) * 16'h0111;
    regs[7] = 16'h2345;
    repeat (3) @(negedge clk);
    chk("R13 req_ready", 32'(req_ready), 32'd1);
    chk("R13 res_valid", 32'(res_valid), 32'd0);
    chk("R13 mem_re", 32'(mem_re), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R13 ready after release", 32'(req_ready), 32'd1);

    for (int v = 0; v < NV; v++)
      run($sformatf("vec%0d", v), VECS[v].mode, VECS[v].field, int'(VECS[v].sel),
          int'(VECS[v].n), 0);

    // R8 post-increment, then register readback through mode 1
    run("R8 postinc", 4'd9, 16'h0000, 4, 1, 0);
    run("R8 postinc readback", 4'd1, 16'h0000, 4, 0, 0);
    chk("R8 reg4 incremented", 32'(res_data), 32'(16'h1000 + 16'h0444 + 16'd1));
    // R8 pre-decrement
    run("R8 predec", 4'd10, 16'h0000, 6, 1, 0);
    run("R8 predec readback", 4'd1, 16'h0000, 6, 0, 0);
    chk("R8 reg6 decremented", 32'(res_data), 32'(16'h1000 + 16'h0666 - 16'd1));
    // R8 non-auto mode leaves register alone
    run("R8 rptr no write", 4'd4, 16'h0000, 2, 1, 0);
    run("R8 rptr readback", 4'd1, 16'h0000, 2, 0, 0);
    chk("R8 reg2 unchanged", 32'(res_data), 32'(16'h1222));

    // R11 back-pressure on a 2-read and a 0-read request
    run("R11 stall ptr", 4'd3, 16'h0300, 0, 2, 3);
    run("R11 stall lit", 4'd0, 16'h5555, 0, 0, 4);
    // R12 another unused code
    run("R12 code15", 4'd15, 16'hBEEF, 1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule